// File: doc/BRIEF.md
# Interval Timer Host Write Path

This block is the host-facing write side of a three-channel programmable interval timer. A host drives an 8-bit data bus, a 2-bit address, an active-low chip select, and active-low read and write strobes. Writes to the all-ones address carry a control word. Writes to any other address carry one byte of a channel's starting count.

A control word names one channel. It either programs that channel's counting mode, number format and byte-access order, or it asks for a snapshot of that channel's count. After a channel is programmed, byte writes to its address build a 16-bit starting count in the chosen order. When the count is complete the block raises a one-cycle load strobe and sets the channel's programmed flag. The counting engines downstream read the per-channel outputs.

Everything runs on one system clock. Strobes are sampled synchronously, and a write takes effect only when its write strobe is released.

Top module: `pit_host_if`

## Requirements
- R1: A write is accepted only if chip select was low and the read strobe high while the write strobe was low. It takes effect at the first clock edge that samples the write strobe high again. At that edge the mode, format and count outputs change, and a pulse output is high for the one cycle that follows.
- R2: In a control word, bits 7:6 select the channel (00, 01, 10 for channels 0, 1, 2). Bits 5:4 give the access code, bits 3:1 the mode and bit 0 the number format (0 binary, 1 decimal). A non-latch control word copies the mode and format to that channel's outputs.
- R3: Mode codes 110 and 111 are reported as modes 2 (010) and 3 (011). The other codes from 000 to 101 are reported unchanged.
- R4: A control word with channel select 11 changes no channel output.
- R5: Access code 00 pulses the selected channel's latch request for one cycle. It leaves that channel's mode, format, count and programmed flag unchanged.
- R6: With access code 01, each count write sets the count to {8'h00, data}, pulses the load strobe and sets the programmed flag.
- R7: With access code 10, each count write sets the count to {data, 8'h00}, pulses the load strobe and sets the programmed flag.
- R8: With access code 11, the first count write is the low byte and the second is the high byte. The count output, the load strobe and the programmed flag change only after the high byte.
- R9: A non-latch control word clears the channel's programmed flag and makes its next count write a low byte. This holds even when a two-byte load is half done.
- R10: After reset every channel reports mode 0, binary format, count 0, and programmed, load and latch low. Count writes to a channel that has had no control word since reset are ignored.
- R11: A write strobe held low for many cycles acts exactly once, on release, and never during the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low; a write is ignored while it is low |
| wr_n | input | 1 | Write strobe, active low; acts on release |
| addr | input | 2 | Register address; 11 is the control word |
| din | input | 8 | Write data |
| mode_o | output | 3x3 | Per-channel operating mode, 0 to 5 |
| bcd_o | output | 3 | Per-channel decimal-format flag |
| count_o | output | 3x16 | Per-channel starting count |
| load_o | output | 3 | Per-channel one-cycle count-loaded strobe |
| prog_o | output | 3 | Per-channel programmed flag |
| latch_o | output | 3 | Per-channel one-cycle latch request |

## Verification
The hardest state to reach is a two-byte load that is half done, with only the low byte written, which a new control word then interrupts. At the ports this state differs from idle only by what the next write does. The stimulus writes a control word, one low byte and a stray byte, then rewrites the control word and sends a fresh byte pair, and checks that the stray byte never reaches the count. A long write-strobe low phase is also checked cycle by cycle to confirm that nothing acts before the release.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  // codes with bit 1 set ignore the top bit (x10 -> 2, x11 -> 3)
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    norm_mode = m[1] ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/pit_wr_capture.sv
module pit_wr_capture #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          wr_q, wr_d;
  logic          sel_q, sel_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    wr_d   = wr_n;
    sel_d  = sel_q;
    addr_d = addr_q;
    data_d = data_q;
    if (!wr_n) begin
      sel_d  = !cs_n && rd_n;
      addr_d = addr;
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      sel_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_d;
      sel_q  <= sel_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_fire = wr_n && !wr_q && sel_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
  import pit_pkg::*;
#(
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input  logic           fire,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  data,
  output logic [NCH-1:0] cfg_we,
  output logic [NCH-1:0] latch_req,
  output logic [NCH-1:0] cnt_we,
  output logic [2:0]     mode,
  output logic           bcd,
  output acc_e           acc
);
  logic          is_ctl;
  logic [AW-1:0] sel;

  assign is_ctl = fire && (addr == {AW{1'b1}});
  assign sel    = data[DW-1 -: AW];
  assign acc    = acc_e'(data[DW-AW-1 -: 2]);
  assign mode   = norm_mode(data[3:1]);
  assign bcd    = data[0];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cfg_we[i]    = is_ctl && (sel == i[AW-1:0]) && (acc != ACC_LATCH);
      latch_req[i] = is_ctl && (sel == i[AW-1:0]) && (acc == ACC_LATCH);
      cnt_we[i]    = fire && !is_ctl && (addr == i[AW-1:0]);
    end
  end
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          latch_req,
  input  logic          cnt_we,
  input  logic [2:0]    mode_in,
  input  logic          bcd_in,
  input  acc_e          acc_in,
  input  logic [DW-1:0] data,
  output logic [2:0]    mode,
  output logic          bcd,
  output logic [2*DW-1:0] count,
  output logic          load,
  output logic          prog,
  output logic          latch
);
  localparam int CW = 2 * DW;

  logic [2:0]    mode_q, mode_d;
  logic          bcd_q, bcd_d;
  acc_e          acc_q, acc_d;
  logic          cfgd_q, cfgd_d;
  logic          tog_q, tog_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prog_q, prog_d;
  logic          load_q, load_d;
  logic          latch_q, latch_d;

  always_comb begin
    mode_d  = mode_q;
    bcd_d   = bcd_q;
    acc_d   = acc_q;
    cfgd_d  = cfgd_q;
    tog_d   = tog_q;
    lo_d    = lo_q;
    cnt_d   = cnt_q;
    prog_d  = prog_q;
    load_d  = 1'b0;
    latch_d = latch_req;
    if (cfg_we) begin
      mode_d = mode_in;
      bcd_d  = bcd_in;
      acc_d  = acc_in;
      cfgd_d = 1'b1;
      tog_d  = 1'b0;
      prog_d = 1'b0;
    end else if (cnt_we && cfgd_q) begin
      case (acc_q)
        ACC_LO: begin
          cnt_d  = {{DW{1'b0}}, data};
          load_d = 1'b1;
          prog_d = 1'b1;
        end
        ACC_HI: begin
          cnt_d  = {data, {DW{1'b0}}};
          load_d = 1'b1;
          prog_d = 1'b1;
        end
        ACC_BOTH: begin
          if (!tog_q) begin
            lo_d  = data;
            tog_d = 1'b1;
          end else begin
            cnt_d  = {data, lo_q};
            tog_d  = 1'b0;
            load_d = 1'b1;
            prog_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      acc_q   <= ACC_LATCH;
      cfgd_q  <= 1'b0;
      tog_q   <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
      prog_q  <= 1'b0;
      load_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      bcd_q   <= bcd_d;
      acc_q   <= acc_d;
      cfgd_q  <= cfgd_d;
      tog_q   <= tog_d;
      lo_q    <= lo_d;
      cnt_q   <= cnt_d;
      prog_q  <= prog_d;
      load_q  <= load_d;
      latch_q <= latch_d;
    end
  end

  assign mode  = mode_q;
  assign bcd   = bcd_q;
  assign count = cnt_q;
  assign load  = load_q;
  assign prog  = prog_q;
  assign latch = latch_q;
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
  import pit_pkg::*;
#(
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            din,
  output logic [NCH-1:0][2:0]      mode_o,
  output logic [NCH-1:0]           bcd_o,
  output logic [NCH-1:0][2*DW-1:0] count_o,
  output logic [NCH-1:0]           load_o,
  output logic [NCH-1:0]           prog_o,
  output logic [NCH-1:0]           latch_o
);
  logic           fire;
  logic [AW-1:0]  w_addr;
  logic [DW-1:0]  w_data;
  logic [NCH-1:0] cfg_we, latch_req, cnt_we;
  logic [2:0]     d_mode;
  logic           d_bcd;
  acc_e           d_acc;

  pit_wr_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .wr_fire(fire), .wr_addr(w_addr), .wr_data(w_data)
  );

  pit_cw_decode #(.AW(AW), .DW(DW), .NCH(NCH)) u_dec (
    .fire(fire), .addr(w_addr), .data(w_data), .cfg_we(cfg_we),
    .latch_req(latch_req), .cnt_we(cnt_we), .mode(d_mode), .bcd(d_bcd), .acc(d_acc)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pit_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[g]), .latch_req(latch_req[g]),
      .cnt_we(cnt_we[g]), .mode_in(d_mode), .bcd_in(d_bcd), .acc_in(d_acc),
      .data(w_data), .mode(mode_o[g]), .bcd(bcd_o[g]), .count(count_o[g]),
      .load(load_o[g]), .prog(prog_o[g]), .latch(latch_o[g])
    );
  end
endmodule

// File: rtl/pit_host_if_chk.sv
module pit_host_if_chk #(
  parameter int DW  = 8,
  parameter int NCH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCH-1:0][2:0]      mode_o,
  input logic [NCH-1:0]           bcd_o,
  input logic [NCH-1:0][2*DW-1:0] count_o,
  input logic [NCH-1:0]           load_o,
  input logic [NCH-1:0]           prog_o,
  input logic [NCH-1:0]           latch_o
);
  // R11: a single write yields at most one pulse
  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o, latch_o}));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[g] <= 3'd5);
    a_r6_load_programs: assert property (@(posedge clk) disable iff (!rst_n)
      load_o[g] |-> prog_o[g]);
    a_r8_prog_rise_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_o[g]) |-> load_o[g]);
    a_r8_count_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_o[g] |-> $stable(count_o[g]));
    a_r5_latch_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o[g] |-> ($stable(mode_o[g]) && $stable(bcd_o[g]) && $stable(prog_o[g])));
  end
endmodule

bind pit_host_if pit_host_if_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .bcd_o(bcd_o), .count_o(count_o),
  .load_o(load_o), .prog_o(prog_o), .latch_o(latch_o)
);

// File: tb/sim_pit_host_if.sv
module sim_pit_host_if;
  logic clk, rst_n, cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] din;
  logic [2:0][2:0]  mode_o;
  logic [2:0]       bcd_o, load_o, prog_o, latch_o;
  logic [2:0][15:0] count_o;

  int checks = 0;
  int errors = 0;

  pit_host_if u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .mode_o(mode_o), .bcd_o(bcd_o), .count_o(count_o),
    .load_o(load_o), .prog_o(prog_o), .latch_o(latch_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  int m_mode[3], m_bcd[3], m_fmt[3], m_tog[3], m_cnt[3], m_lo[3];
  int m_prog[3], m_load[3], m_latch[3], m_cfgd[3];
  int m_prev, m_sel, m_addr, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_mode[i] = 0; m_bcd[i] = 0; m_fmt[i] = 0; m_tog[i] = 0; m_cnt[i] = 0;
        m_lo[i] = 0; m_prog[i] = 0; m_load[i] = 0; m_latch[i] = 0; m_cfgd[i] = 0;
      end
      m_prev = 1; m_sel = 0; m_addr = 0; m_data = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin m_load[i] = 0; m_latch[i] = 0; end
      if (wr_n === 1'b1 && m_prev == 0 && m_sel == 1) begin
        if (m_addr == 3) begin
          int sc, rw, md;
          sc = m_data / 64; rw = (m_data / 16) % 4; md = (m_data / 2) % 8;
          if (md >= 6) md = md - 4;
          if (sc < 3) begin
            if (rw == 0) m_latch[sc] = 1;
            else begin
              m_mode[sc] = md; m_bcd[sc] = m_data % 2; m_fmt[sc] = rw;
              m_tog[sc] = 0; m_prog[sc] = 0; m_cfgd[sc] = 1;
            end
          end
        end else if (m_cfgd[m_addr] == 1) begin
          int c;
          c = m_addr;
          if (m_fmt[c] == 1) begin m_cnt[c] = m_data; m_load[c] = 1; m_prog[c] = 1; end
          else if (m_fmt[c] == 2) begin m_cnt[c] = m_data * 256; m_load[c] = 1; m_prog[c] = 1; end
          else if (m_fmt[c] == 3) begin
            if (m_tog[c] == 0) begin m_lo[c] = m_data; m_tog[c] = 1; end
            else begin
              m_cnt[c] = m_data * 256 + m_lo[c]; m_tog[c] = 0; m_load[c] = 1; m_prog[c] = 1;
            end
          end
        end
      end
      if (wr_n === 1'b0) begin
        m_sel = (cs_n === 1'b0 && rd_n === 1'b1) ? 1 : 0;
        m_addr = addr; m_data = din;
      end
      m_prev = (wr_n === 1'b1) ? 1 : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R1 timing of every output)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        chk("R1 model mode", mode_o[i], m_mode[i]);
        chk("R1 model bcd", bcd_o[i], m_bcd[i]);
        chk("R1 model count", count_o[i], m_cnt[i]);
        chk("R1 model prog", prog_o[i], m_prog[i]);
        chk("R1 model load", load_o[i], m_load[i]);
        chk("R1 model latch", latch_o[i], m_latch[i]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d,
                    input logic cs = 1'b0, input logic rd = 1'b1, input int hold = 2);
    @(negedge clk);
    addr = a; din = d; cs_n = cs; rd_n = rd; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 2'b00; din = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset mode", mode_o[0], 0);
    chk("R10 reset prog", prog_o, 0);
    chk("R10 reset count", count_o[2], 0);

    wr(2'd0, 8'h99);
    chk("R10 unconfigured write count", count_o[0], 0);
    chk("R10 unconfigured write load", load_o[0], 0);

    wr(2'd3, 8'h17);                       // ch0 low-only, mode 3, decimal
    chk("R2 mode ch0", mode_o[0], 3);
    chk("R2 bcd ch0", bcd_o[0], 1);
    wr(2'd0, 8'h5A);
    chk("R6 load pulse", load_o[0], 1);
    chk("R6 count low only", count_o[0], 16'h005A);
    chk("R6 programmed", prog_o[0], 1);

    wr(2'd3, 8'h6C);                       // ch1 high-only, mode code 110
    chk("R3 mode 110 -> 2", mode_o[1], 2);
    wr(2'd1, 8'h34);
    chk("R7 count high only", count_o[1], 16'h3400);
    chk("R7 load pulse", load_o[1], 1);

    wr(2'd3, 8'hBE);                       // ch2 two-byte, mode code 111
    chk("R3 mode 111 -> 3", mode_o[2], 3);
    wr(2'd2, 8'h11);
    chk("R8 no load after low byte", load_o[2], 0);
    chk("R8 count held after low byte", count_o[2], 0);
    chk("R8 not programmed after low", prog_o[2], 0);
    wr(2'd2, 8'h22);
    chk("R8 count after high byte", count_o[2], 16'h2211);
    chk("R8 load after high byte", load_o[2], 1);

    wr(2'd2, 8'h33);                       // half-done load
    wr(2'd3, 8'hBE);
    chk("R9 prog cleared", prog_o[2], 0);
    wr(2'd2, 8'h44);
    chk("R9 low byte restarts", load_o[2], 0);
    wr(2'd2, 8'h55);
    chk("R9 count after restart", count_o[2], 16'h5544);

    wr(2'd3, 8'h40);                       // latch ch1
    chk("R5 latch pulse", latch_o[1], 1);
    chk("R5 mode kept", mode_o[1], 2);
    chk("R5 count kept", count_o[1], 16'h3400);
    chk("R5 prog kept", prog_o[1], 1);

    wr(2'd3, 8'hFE);                       // select 11
    chk("R4 ch0 mode kept", mode_o[0], 3);
    chk("R4 ch2 prog kept", prog_o[2], 1);

    wr(2'd3, 8'h30, 1'b1);                 // chip select high
    chk("R1 cs high ignored", mode_o[0], 3);
    wr(2'd3, 8'h30, 1'b0, 1'b0);           // read strobe low
    chk("R1 rd low ignored", mode_o[0], 3);

    @(negedge clk);
    addr = 2'd3; din = 8'h38; cs_n = 1'b0; wr_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R11 no action while low", mode_o[0], 3);
    end
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk("R11 action on release", mode_o[0], 4);
    @(negedge clk);
    chk("R11 single action", prog_o[0], 0);

    wr(2'd3, 8'h1A);
    chk("R2 mode 5", mode_o[0], 5);
    chk("R2 bcd binary", bcd_o[0], 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule